// File: doc/BRIEF.md
# Multiplexed Boot ROM Bus Sequencer

This block runs accesses to an external byte-wide boot ROM that shares one 8-bit bus for address, control and data. A client hands it a 16-bit byte address, a read/write flag, a byte count of one to four and, for writes, up to four bytes. The block then drives two address cycles and one to four data cycles on the shared bus. The first address cycle packs the upper six bits of the low address byte together with the two active-low strobes. The second address cycle carries the high address byte. The data cycles then move bytes 0 upward within the selected four-byte group.

On reads the block releases the bus during each data cycle and samples it at the end of that cycle. Each captured byte comes back one cycle later with a valid strobe and its index within the group. A busy flag covers the whole access, and requests that arrive while it is high are dropped.

One bus line also serves as a strap input. Its level is captured on every clock while reset is held, so the level present in the last reset cycle is kept as a configuration bit. After reset that line behaves like any other bus line and no longer changes the stored bit.

Top module: `bootrom_mux_seq`

## Requirements
- R1: After reset, `busy`, `bus_oe` and `rd_valid` are low and `bus_out` is zero.
- R2: A request presented with `req_valid` while `busy` is low is accepted at that clock edge. `busy` is high from the next cycle for exactly 2 + (`req_len_m1` + 1) cycles and then falls.
- R3: The first busy cycle drives the bus (`bus_oe` high) with `bus_out[5:0]` = address bits 7:2, `bus_out[6]` = output-enable (active low) and `bus_out[7]` = write-enable (active low). A read sends bits 7:6 = 2'b10 and a write sends 2'b01.
- R4: The second busy cycle drives the bus with address bits 15:8.
- R5: On a write, data cycle k (k = 0 .. `req_len_m1`) drives the bus with `req_wdata[8k+7:8k]`.
- R6: On a read, `bus_oe` is low in every data cycle and `bus_in` is sampled at the end of the cycle. In the following cycle `rd_valid` is high and `rd_data` holds that byte.
- R7: Address bits 1:0 are never sent. Data cycles always cover bytes 0, 1, … in increasing order, and `rd_idx` reports the byte index (0 for the first read byte), whatever the low address bits are.
- R8: `cfg_strap` takes the value of `bus_in[1]` from the last clock of reset. While reset is released it does not change, whatever `bus_in` carries.
- R9: A `req_valid` while `busy` is high is ignored. The running access's bus cycles are unchanged, and no extra access follows.
- R10: Whenever `busy` is low, `bus_oe` is low and `bus_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampling window |
| req_valid | input | 1 | Request strobe, taken only when not busy |
| req_addr | input | 16 | ROM byte address; bits 1:0 unused |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_len_m1 | input | 2 | Number of data bytes minus one |
| req_wdata | input | 32 | Write bytes, byte k in bits 8k+7:8k |
| busy | output | 1 | Access in progress |
| bus_in | input | 8 | Value seen on the shared bus pads |
| bus_out | output | 8 | Value driven toward the shared bus pads |
| bus_oe | output | 1 | Pad driver enable |
| rd_valid | output | 1 | Read byte valid strobe |
| rd_data | output | 8 | Read byte |
| rd_idx | output | 2 | Index of the read byte within its group |
| cfg_strap | output | 1 | Strap level captured during reset |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, with the strap taken from line 1. With these values the two-bit strobe field and the six address bits fill the first address cycle exactly. Every byte count from one to four is reachable, both directions are exercised, and the ROM model feeds read bytes that toggle the strap line, so any leak into the captured strap would show. Two reset passes, one with each strap level, cover both captured values.

// File: rtl/bootrom_mux_pkg.sv
package bootrom_mux_pkg;

    // Bus phase of the sequencer
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ADDR_LO = 2'd1,
        PH_ADDR_HI = 2'd2,
        PH_DATA    = 2'd3
    } brom_phase_e;

    // Byte index within one addressed group (group of four bytes)
    localparam int GRP_IDX_W = 2;

endpackage

// File: rtl/bootrom_seq_ctrl.sv
module bootrom_seq_ctrl
    import bootrom_mux_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [2*BUS_W-1:0]      req_addr,
    input  logic                    req_write,
    input  logic [GRP_IDX_W-1:0]    req_len_m1,
    input  logic [BUS_W*(1<<GRP_IDX_W)-1:0] req_wdata,
    output logic                    busy,
    output brom_phase_e             phase,
    output logic [GRP_IDX_W-1:0]    idx,
    output logic                    is_write,
    output logic [2*BUS_W-1:0]      addr,
    output logic [BUS_W*(1<<GRP_IDX_W)-1:0] wdata
);
    localparam int ADDR_W = 2 * BUS_W;
    localparam int DATA_W = BUS_W * (1 << GRP_IDX_W);

    typedef struct packed {
        brom_phase_e          phase;
        logic [ADDR_W-1:0]    addr;
        logic                 write;
        logic [GRP_IDX_W-1:0] last;
        logic [GRP_IDX_W-1:0] idx;
        logic [DATA_W-1:0]    wdata;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_ADDR_LO;
                    st_d.addr  = req_addr;
                    st_d.write = req_write;
                    st_d.last  = req_len_m1;
                    st_d.idx   = '0;
                    st_d.wdata = req_wdata;
                end
            end
            PH_ADDR_LO: st_d.phase = PH_ADDR_HI;
            PH_ADDR_HI: begin
                st_d.phase = PH_DATA;
                st_d.idx   = '0;
            end
            PH_DATA: begin
                if (st_q.idx == st_q.last) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase != PH_IDLE);
    assign phase    = st_q.phase;
    assign idx      = st_q.idx;
    assign is_write = st_q.write;
    assign addr     = st_q.addr;
    assign wdata    = st_q.wdata;

endmodule

// File: rtl/bootrom_bus_fmt.sv
module bootrom_bus_fmt
    import bootrom_mux_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  brom_phase_e             phase,
    input  logic [GRP_IDX_W-1:0]    idx,
    input  logic                    is_write,
    input  logic [2*BUS_W-1:0]      addr,
    input  logic [BUS_W*(1<<GRP_IDX_W)-1:0] wdata,
    output logic [BUS_W-1:0]        bus_out,
    output logic                    bus_oe
);
    // First address cycle: {write strobe_n, read strobe_n, addr[BUS_W-1:GRP_IDX_W]}
    logic [BUS_W-1:0] lo_frame;
    logic             we_n;
    logic             oe_n;

    assign we_n     = ~is_write;
    assign oe_n     = is_write;
    assign lo_frame = {we_n, oe_n, addr[BUS_W-1:GRP_IDX_W]};

    always_comb begin
        bus_out = '0;
        bus_oe  = 1'b0;
        unique case (phase)
            PH_ADDR_LO: begin
                bus_out = lo_frame;
                bus_oe  = 1'b1;
            end
            PH_ADDR_HI: begin
                bus_out = addr[2*BUS_W-1:BUS_W];
                bus_oe  = 1'b1;
            end
            PH_DATA: begin
                if (is_write) begin
                    bus_out = wdata[idx*BUS_W +: BUS_W];
                    bus_oe  = 1'b1;
                end
            end
            default: begin
                bus_out = '0;
                bus_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bootrom_rd_capture.sv
module bootrom_rd_capture
    import bootrom_mux_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample,
    input  logic [GRP_IDX_W-1:0] idx,
    input  logic [BUS_W-1:0]     bus_in,
    output logic                 rd_valid,
    output logic [BUS_W-1:0]     rd_data,
    output logic [GRP_IDX_W-1:0] rd_idx
);
    typedef struct packed {
        logic                 valid;
        logic [BUS_W-1:0]     data;
        logic [GRP_IDX_W-1:0] idx;
    } cap_state_t;

    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = sample;
        if (sample) begin
            cap_d.data = bus_in;
            cap_d.idx  = idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_valid = cap_q.valid;
    assign rd_data  = cap_q.data;
    assign rd_idx   = cap_q.idx;

endmodule

// File: rtl/bootrom_strap_latch.sv
module bootrom_strap_latch #(
    parameter int BUS_W     = 8,
    parameter int STRAP_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_in,
    output logic             strap
);
    logic strap_d, strap_q;

    // Tracks the pad while reset is held; frozen once reset is released
    always_comb begin
        strap_d = rst_n ? strap_q : bus_in[STRAP_BIT];
    end

    always_ff @(posedge clk) begin
        strap_q <= strap_d;
    end

    assign strap = strap_q;

endmodule

// File: rtl/bootrom_mux_seq.sv
module bootrom_mux_seq
    import bootrom_mux_pkg::*;
#(
    parameter int BUS_W     = 8,
    parameter int STRAP_BIT = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2*BUS_W-1:0]    req_addr,
    input  logic                  req_write,
    input  logic [GRP_IDX_W-1:0]  req_len_m1,
    input  logic [BUS_W*(1<<GRP_IDX_W)-1:0] req_wdata,
    output logic                  busy,
    input  logic [BUS_W-1:0]      bus_in,
    output logic [BUS_W-1:0]      bus_out,
    output logic                  bus_oe,
    output logic                  rd_valid,
    output logic [BUS_W-1:0]      rd_data,
    output logic [GRP_IDX_W-1:0]  rd_idx,
    output logic                  cfg_strap
);
    localparam int ADDR_W = 2 * BUS_W;
    localparam int DATA_W = BUS_W * (1 << GRP_IDX_W);

    brom_phase_e          phase_w;
    logic [GRP_IDX_W-1:0] idx_w;
    logic                 write_w;
    logic [ADDR_W-1:0]    addr_w;
    logic [DATA_W-1:0]    wdata_w;
    logic                 sample_w;

    bootrom_seq_ctrl #(.BUS_W(BUS_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_len_m1 (req_len_m1),
        .req_wdata  (req_wdata),
        .busy       (busy),
        .phase      (phase_w),
        .idx        (idx_w),
        .is_write   (write_w),
        .addr       (addr_w),
        .wdata      (wdata_w)
    );

    bootrom_bus_fmt #(.BUS_W(BUS_W)) u_fmt (
        .phase    (phase_w),
        .idx      (idx_w),
        .is_write (write_w),
        .addr     (addr_w),
        .wdata    (wdata_w),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe)
    );

    assign sample_w = (phase_w == PH_DATA) && !write_w;

    bootrom_rd_capture #(.BUS_W(BUS_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample_w),
        .idx      (idx_w),
        .bus_in   (bus_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx)
    );

    bootrom_strap_latch #(.BUS_W(BUS_W), .STRAP_BIT(STRAP_BIT)) u_strap (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_in (bus_in),
        .strap  (cfg_strap)
    );

endmodule

// File: rtl/bootrom_mux_seq_chk.sv
module bootrom_mux_seq_chk #(
    parameter int BUS_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               busy,
    input logic [BUS_W-1:0]   bus_out,
    input logic               bus_oe,
    input logic               rd_valid,
    input logic               cfg_strap,
    input logic [2*BUS_W-1:0] addr_w
);
    // R2: an idle request starts an access on the next cycle
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R3: first address cycle is driven with exactly one strobe asserted
    assert_lo_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (bus_oe && ($countones(bus_out[BUS_W-1 -: 2]) == 1)));

    // R4: second address cycle is driven
    assert_hi_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (busy && bus_oe));

    // R6: a read strobe follows a busy cycle with the bus released
    assert_rd_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(busy) && !$past(bus_oe)));

    // R8: strap holds while out of reset
    assert_strap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_strap));

    // R9: captured address is not replaced during an access
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_w));

    // R10: idle bus is released and quiet
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_oe && (bus_out == '0)));

endmodule

bind bootrom_mux_seq bootrom_mux_seq_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .rd_valid  (rd_valid),
    .cfg_strap (cfg_strap),
    .addr_w    (addr_w)
);

// File: tb/tb_bootrom_mux_seq.sv
`timescale 1ns/1ps
module tb_bootrom_mux_seq;

    localparam int BUS_W = 8;

    typedef struct packed {
        logic       oe;
        logic [7:0] data;
        logic [3:0] tag;
    } cyc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_len_m1 = '0;
    logic [31:0] req_wdata = '0;
    logic        busy;
    logic [7:0]  bus_in;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [1:0]  rd_idx;
    logic        cfg_strap;

    logic [7:0]  rom_val = 8'h00;
    logic        strap_val = 1'b1;

    cyc_t       busq[$];
    logic [7:0] romq[$];
    logic [9:0] rdq[$];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign bus_in = rst_n ? rom_val : {6'b0, strap_val, 1'b0};

    bootrom_mux_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_len_m1 (req_len_m1),
        .req_wdata  (req_wdata),
        .busy       (busy),
        .bus_in     (bus_in),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_idx     (rd_idx),
        .cfg_strap  (cfg_strap)
    );

    task automatic chk(input bit ok, input int req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_byte(input logic [15:0] a, input int k);
        return a[15:8] ^ {a[7:2], 2'b00} ^ (8'h5A + 8'(k * 8'h37));
    endfunction

    // Driver: pushes the expected bus cycles and read bytes, then issues the request
    task automatic do_req(input logic [15:0] a, input logic wr, input logic [1:0] len,
                          input logic [31:0] wd, input bit poke);
        int cnt;
        while (busy) @(negedge clk);
        busq.push_back('{1'b1, {~wr, wr, a[7:2]}, 4'd3});          // R3
        busq.push_back('{1'b1, a[15:8], 4'd4});                    // R4
        for (int k = 0; k <= int'(len); k++) begin
            if (wr) begin
                busq.push_back('{1'b1, wd[k*8 +: 8], 4'd5});      // R5
            end else begin
                busq.push_back('{1'b0, 8'h00, 4'd6});             // R6
                romq.push_back(rom_byte(a, k));
                rdq.push_back({2'(k), rom_byte(a, k)});
            end
        end
        req_addr   = a;
        req_write  = wr;
        req_len_m1 = len;
        req_wdata  = wd;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        cnt = 0;
        while (busy) begin
            cnt++;
            if (poke) begin
                // R9: competing request while busy
                req_valid = 1'b1;
                req_addr  = ~a;
                req_write = ~wr;
                req_len_m1 = 2'd3;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(cnt == 3 + int'(len), 2, "busy length", cnt, 3 + int'(len)); // R2
        chk(busq.size() == 0, 9, "bus cycles left", busq.size(), 0);
    endtask

    // Monitor: pops expected bus cycles and read results
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                if (busq.size() == 0) begin
                    chk(1'b0, 9, "unexpected bus cycle", bus_out, 0);
                end else begin
                    cyc_t e;
                    e = busq.pop_front();
                    chk(bus_oe == e.oe, int'(e.tag), "bus_oe", bus_oe, e.oe);
                    if (e.oe) chk(bus_out == e.data, int'(e.tag), "bus_out", bus_out, e.data);
                end
                if (!bus_oe && romq.size() != 0) rom_val = romq.pop_front();
            end else begin
                // R10
                chk(!bus_oe && bus_out == 8'h00, 10, "idle bus", {bus_oe, bus_out}, 0);
            end
            if (rd_valid) begin
                if (rdq.size() == 0) begin
                    chk(1'b0, 6, "unexpected rd_valid", rd_data, 0);
                end else begin
                    logic [9:0] r;
                    r = rdq.pop_front();
                    chk(rd_data == r[7:0], 6, "rd_data", rd_data, r[7:0]);
                    chk(rd_idx == r[9:8], 7, "rd_idx", rd_idx, r[9:8]);   // R7
                end
            end
        end
    end

    task automatic apply_reset(input logic s);
        strap_val = s;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        apply_reset(1'b1);
        // R1: idle after reset
        chk(busy == 1'b0, 1, "busy", busy, 0);
        chk(bus_oe == 1'b0 && bus_out == 8'h00, 1, "bus idle", {bus_oe, bus_out}, 0);
        chk(rd_valid == 1'b0, 1, "rd_valid", rd_valid, 0);
        chk(cfg_strap == 1'b1, 8, "strap high", cfg_strap, 1);      // R8

        do_req(16'hA5C4, 1'b0, 2'd3, 32'h0, 1'b0);
        do_req(16'h3C7B, 1'b1, 2'd0, 32'hDEADBE11, 1'b0);
        do_req(16'h8001, 1'b1, 2'd3, 32'h44332211, 1'b0);
        do_req(16'hFFFF, 1'b0, 2'd0, 32'h0, 1'b0);
        // R7: same group, different low bits, same bus cycles and indices
        do_req(16'h12F0, 1'b0, 2'd1, 32'h0, 1'b0);
        do_req(16'h12F3, 1'b0, 2'd1, 32'h0, 1'b0);
        do_req(16'h0E5A, 1'b1, 2'd2, 32'h00C0FFEE, 1'b0);
        // R9: requests while busy are dropped
        do_req(16'h6B9C, 1'b0, 2'd3, 32'h0, 1'b1);
        do_req(16'h2468, 1'b1, 2'd1, 32'hA5A55A5A, 1'b1);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, 9, "no access after poke", busy, 0);
        chk(rdq.size() == 0, 6, "read bytes left", rdq.size(), 0);
        chk(cfg_strap == 1'b1, 8, "strap held after traffic", cfg_strap, 1);

        apply_reset(1'b0);
        chk(cfg_strap == 1'b0, 8, "strap low", cfg_strap, 0);
        chk(busy == 1'b0, 1, "busy after 2nd reset", busy, 0);
        do_req(16'hC3A6, 1'b0, 2'd3, 32'h0, 1'b0);
        do_req(16'h5511, 1'b0, 2'd2, 32'h0, 1'b0);
        repeat (3) @(negedge clk);
        chk(cfg_strap == 1'b0, 8, "strap low held", cfg_strap, 0);
        chk(rdq.size() == 0, 6, "read bytes left 2", rdq.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule